// File: doc/BRIEF.md
# Stereo Serial Word Loader

This block is the digital front end of a two-channel audio converter. A single bit clock from the upstream filter is shared by both channels. Each channel has its own serial data line and its own active-low load strobe. On every rising bit-clock edge, each channel appends its data bit to a private shift register. A falling edge on a channel's load strobe copies the newest 18 bits of that shift register into the channel's output word. The output word is a signed two's-complement sample that was sent most-significant bit first.

All five serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected after synchronization, in the system clock domain. The shift register never stops shifting. Bits older than the newest 18 fall off the top, so a load captures the latest 18 bits no matter how many bits came before it. Each channel also gives a one-cycle update pulse in the same cycle that its output word takes a new value. The strobes may be wired together so that both channels load on one edge. The data lines may also be wired together.

Top module: `stereo_serial_loader`

## Requirements
- R1: While reset is held and after it is released, both output words read 18'h00000 (midscale) and neither update pulse is high until a load strobe falls.
- R2: Data bits are taken on rising bit-clock edges and arranged most-significant bit first, so after 18 bits the word equals the transmitted two's-complement value, including 18'h20000, 18'h1FFFF and 18'h3FFFF.
- R3: When more than 18 bits arrive between loads, only the newest 18 are captured.
- R4: When fewer than 18 bits arrive between loads, the word is the newest 18 bits shifted overall, with older bits in the upper positions.
- R5: The channels are independent. A load on one channel leaves the other channel's word and update pulse untouched, and each channel shifts only its own data line.
- R6: If both strobes fall together, both words update in the same system cycle.
- R7: With both data lines carrying the same stream, both channels capture identical words.
- R8: The update pulse is high for exactly one system cycle. With the default two synchronizer stages, it appears 3 system cycles after the strobe input falls, in the same cycle the word changes.
- R9: A second load with no bit-clock edge in between captures the same word again and pulses the update again.
- R10: Changes on a data line while the bit clock is steady have no effect on the captured word.
- R11: A rising edge on a load strobe produces no update and changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_in | input | 1 | Shared serial bit clock, asynchronous |
| dat_l_in | input | 1 | Left serial data, asynchronous |
| dat_r_in | input | 1 | Right serial data, asynchronous |
| ld_l_n_in | input | 1 | Left load strobe, active low, falling edge loads |
| ld_r_n_in | input | 1 | Right load strobe, active low, falling edge loads |
| word_l | output | 18 | Left sample, two's complement |
| word_r | output | 18 | Right sample, two's complement |
| upd_l | output | 1 | One-cycle pulse when word_l is loaded |
| upd_r | output | 1 | One-cycle pulse when word_r is loaded |

## Verification
A strobe change is driven just after system edge N. It reaches the second synchronizer stage at edge N+2. The word and the update pulse then change at edge N+3. Each bench load records the cycle number at which it drives the strobe, together with the expected word, taken from a shift model of the bits it has sent. The monitor samples on the falling system clock. For every pulse, it requires the cycle number to be exactly three higher than the recorded one, and it requires the pulse to be gone by the following sample. Data is set up several system cycles before each bit-clock rise and held after it, so the sampled bit never depends on the synchronizer phase.

// File: rtl/stereo_serial_loader.sv
module stereo_serial_loader #(
  parameter int WORD_W   = 18,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck_in,
  input  logic              dat_l_in,
  input  logic              dat_r_in,
  input  logic              ld_l_n_in,
  input  logic              ld_r_n_in,
  output logic [WORD_W-1:0] word_l,
  output logic [WORD_W-1:0] word_r,
  output logic              upd_l,
  output logic              upd_r
);
  localparam int NIN = 5;
  localparam logic [NIN-1:0] IDLE = 5'b11000;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] sync_q [SYNC_LEN];
  logic [NIN-1:0] prev_q;
  logic [NIN-1:0] now_s;
  logic [WORD_W-1:0] sh_l, sh_r, nxt_l, nxt_r;
  logic bck_rise, fall_l, fall_r;

  assign raw = {ld_r_n_in, ld_l_n_in, dat_r_in, dat_l_in, bck_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_LEN; i++) sync_q[i] <= IDLE;
      prev_q <= IDLE;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_LEN; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_LEN-1];
    end
  end

  assign now_s    = sync_q[SYNC_LEN-1];
  assign bck_rise = now_s[0] & ~prev_q[0];
  assign fall_l   = ~now_s[3] & prev_q[3];
  assign fall_r   = ~now_s[4] & prev_q[4];

  assign nxt_l = bck_rise ? {sh_l[WORD_W-2:0], now_s[1]} : sh_l;
  assign nxt_r = bck_rise ? {sh_r[WORD_W-2:0], now_s[2]} : sh_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l   <= '0;
      sh_r   <= '0;
      word_l <= '0;
      word_r <= '0;
      upd_l  <= 1'b0;
      upd_r  <= 1'b0;
    end else begin
      sh_l  <= nxt_l;
      sh_r  <= nxt_r;
      upd_l <= fall_l;
      upd_r <= fall_r;
      if (fall_l) word_l <= nxt_l;
      if (fall_r) word_r <= nxt_r;
    end
  end

  a_r8_pulse_l: assert property (@(posedge clk) disable iff (!rst_n) upd_l |=> !upd_l);
  a_r8_pulse_r: assert property (@(posedge clk) disable iff (!rst_n) upd_r |=> !upd_r);
  a_r3_hold_l: assert property (@(posedge clk) disable iff (!rst_n) !$stable(word_l) |-> upd_l);
  a_r3_hold_r: assert property (@(posedge clk) disable iff (!rst_n) !$stable(word_r) |-> upd_r);
  a_r11_strobe_low_l: assert property (@(posedge clk) disable iff (!rst_n) upd_l |-> !prev_q[3]);
  a_r11_strobe_low_r: assert property (@(posedge clk) disable iff (!rst_n) upd_r |-> !prev_q[4]);
endmodule

// File: tb/stereo_serial_loader_bench.sv
module stereo_serial_loader_bench;
  localparam int W = 18;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck = 1'b0, dl = 1'b0, dr = 1'b0, ll = 1'b1, lr = 1'b1;
  logic [W-1:0] word_l, word_r;
  logic upd_l, upd_r;

  stereo_serial_loader u_stereo_serial_loader (
    .clk(clk), .rst_n(rst_n), .bck_in(bck), .dat_l_in(dl), .dat_r_in(dr),
    .ld_l_n_in(ll), .ld_r_n_in(lr), .word_l(word_l), .word_r(word_r),
    .upd_l(upd_l), .upd_r(upd_r));

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic [W-1:0] exp_l = '0, exp_r = '0;
  logic [W-1:0] ql_val[$], qr_val[$];
  int ql_due[$], qr_due[$];
  string ql_tag[$], qr_tag[$];
  int pushed_l = 0, pushed_r = 0, seen_l = 0, seen_r = 0;
  logic last_ul = 1'b0, last_ur = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_l) begin
        seen_l++;
        chk(!last_ul, "R8 left pulse width", 1, 0);
        if (ql_val.size() == 0) chk(1'b0, "R11 left unexpected update", 1, 0);
        else begin
          logic [W-1:0] v; int d; string t;
          v = ql_val.pop_front(); d = ql_due.pop_front(); t = ql_tag.pop_front();
          chk(word_l == v, {t, " left word"}, word_l, v);
          chk(cyc == d, "R8 left latency", cyc, d);
        end
      end
      if (upd_r) begin
        seen_r++;
        chk(!last_ur, "R8 right pulse width", 1, 0);
        if (qr_val.size() == 0) chk(1'b0, "R11 right unexpected update", 1, 0);
        else begin
          logic [W-1:0] v; int d; string t;
          v = qr_val.pop_front(); d = qr_due.pop_front(); t = qr_tag.pop_front();
          chk(word_r == v, {t, " right word"}, word_r, v);
          chk(cyc == d, "R8 right latency", cyc, d);
        end
      end
    end
    last_ul = upd_l;
    last_ur = upd_r;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic bl, input logic br, input bit glitch);
    @(negedge clk);
    dl = bl; dr = br;
    idle(3);
    bck = 1'b1;
    exp_l = {exp_l[W-2:0], bl};
    exp_r = {exp_r[W-2:0], br};
    idle(4);
    bck = 1'b0;
    if (glitch) begin
      idle(1); dl = ~dl; dr = ~dr;
      idle(1); dl = ~dl; dr = ~dr;
      idle(1); dl = ~dl; dr = ~dr;
    end
    idle(3);
  endtask

  task automatic send(input logic [31:0] lw, input logic [31:0] rw, input int n, input bit glitch);
    for (int i = n - 1; i >= 0; i--) clock_bit(lw[i], rw[i], glitch);
  endtask

  task automatic load(input bit do_l, input bit do_r, input string tag);
    @(negedge clk);
    if (do_l) begin
      ll = 1'b0; ql_val.push_back(exp_l); ql_due.push_back(cyc + LAT); ql_tag.push_back(tag); pushed_l++;
    end
    if (do_r) begin
      lr = 1'b0; qr_val.push_back(exp_r); qr_due.push_back(cyc + LAT); qr_tag.push_back(tag); pushed_r++;
    end
    idle(5);
    ll = 1'b1; lr = 1'b1;
    idle(8);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    idle(3);
    chk(word_l == 0 && word_r == 0, "R1 words during reset", {word_l, word_r}, 0);
    chk(!upd_l && !upd_r, "R1 no pulse during reset", {upd_l, upd_r}, 0);
    rst_n = 1'b1;
    idle(6);
    chk(word_l == 0 && word_r == 0, "R1 words after reset", {word_l, word_r}, 0);
    chk(seen_l == 0 && seen_r == 0, "R1 no pulse after reset", seen_l + seen_r, 0);

    send(32'h2A5C3, 32'h1F00F, W, 1'b0);
    load(1'b1, 1'b0, "R2");
    chk(word_r == 0, "R5 right untouched by left load", word_r, 0);
    load(1'b0, 1'b1, "R5");
    chk(word_l == 18'h2A5C3, "R5 left untouched by right load", word_l, 18'h2A5C3);

    send(32'h20000, 32'h1FFFF, W, 1'b0);
    load(1'b1, 1'b1, "R2");
    send(32'h3FFFF, 32'h00001, W, 1'b0);
    load(1'b1, 1'b1, "R6");

    send(32'h2D3_9ABC, 32'h15A_5A5A, 22, 1'b0);
    load(1'b1, 1'b1, "R3");
    chk(word_l == 18'h39ABC, "R3 newest 18 bits left", word_l, 18'h39ABC);

    send(32'h155, 32'h2AA, 10, 1'b0);
    load(1'b1, 1'b0, "R4");
    load(1'b0, 1'b1, "R4");

    send(32'h13579, 32'h13579, W, 1'b0);
    load(1'b1, 1'b1, "R7");
    chk(word_l == word_r, "R7 tied data identical", word_l, word_r);

    load(1'b1, 1'b1, "R9");
    chk(word_l == 18'h13579, "R9 reload same word", word_l, 18'h13579);

    send(32'h0C3A5, 32'h3035A, W, 1'b1);
    load(1'b1, 1'b1, "R10");
    chk(word_l == 18'h0C3A5 && word_r == 18'h3035A, "R10 glitches ignored",
        {word_l, word_r}, {18'h0C3A5, 18'h3035A});

    idle(20);
    chk(seen_l == pushed_l, "R11 left update count", seen_l, pushed_l);
    chk(seen_r == pushed_r, "R11 right update count", seen_r, pushed_r);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end
endmodule